// File: doc/BRIEF.md
# Ethernet Receive Frame Status and Interrupt

This block sits at the end of an Ethernet MAC receive path. Each incoming frame produces one end-of-frame strobe. The strobe carries the frame byte count, a flag that marks a bad frame check sequence, and a flag that marks a receive FIFO overflow while the frame was arriving. From these inputs and two mode bits, the block decides whether the frame is kept or discarded. It reports that verdict one cycle later. In the same cycle it sets sticky status bits for a good reception, an over-length frame, a FIFO overflow and a CRC failure.

Software reaches three small registers through a single-cycle register port: status, interrupt enable and mode. A status bit is cleared by writing a one to its position. The single receive interrupt output is the OR of every status bit whose enable bit is set. Setting the long-frame mode bit or the bad-CRC mode bit reclassifies that kind of frame as good. In that case the block keeps the frame and leaves the matching error bit clear.

Top module: `rx_frame_status`

## Requirements
- R1: A frame longer than 1518 bytes (length 1519 or more) is dropped and sets status bit 3, unless mode bit 0 (accept long frames) is 1. A frame of exactly 1518 bytes is not over-length.
- R2: With mode bit 0 set, an over-length frame is kept as good, sets status bit 4, and leaves status bit 3 unchanged.
- R3: A frame flagged with a CRC failure is dropped and sets status bit 1, unless mode bit 1 (accept bad-CRC frames) is 1.
- R4: With mode bit 1 set, a frame with a CRC failure is kept as good, and status bit 1 is not set.
- R5: A frame with the FIFO overflow flag set is always dropped and sets status bit 2. The mode bits do not change this.
- R6: Status bit 4 (good) is set only by a kept frame. A dropped frame leaves bit 4 unchanged. The verdict appears on verdict_valid/verdict_accept in the cycle after the end-of-frame strobe.
- R7: Writing status (address 0) clears each bit written as 1. Bits written as 0 keep their value.
- R8: rx_irq is high exactly when some status bit is high and the enable bit at the same position (address 1, bits 4..1) is 1.
- R9: The register map is as follows. Address 0 holds status: bit 4 good, bit 3 too long, bit 2 overflow, bit 1 CRC error. Address 1 holds the enables in the same positions. Address 2 holds mode in bits 1..0. All other bits and address 3 read as 0.
- R10: When a hardware set and a write-1 clear hit the same status bit in one cycle, the bit ends up set.
- R11: When one frame meets several drop conditions, every matching error bit is set in the same cycle.
- R12: A synchronous active-high reset clears status, enable and mode to 0. It also clears the verdict outputs and leaves rx_irq low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eof_valid | input | 1 | End-of-frame strobe, one cycle per frame |
| frame_len | input | 16 | Frame byte count, valid with eof_valid |
| crc_bad | input | 1 | Frame check sequence failed, valid with eof_valid |
| fifo_ovf | input | 1 | FIFO overflowed during this frame, valid with eof_valid |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 5 | Register write data |
| reg_rdata | output | 5 | Register read data for reg_addr (combinational) |
| verdict_valid | output | 1 | Verdict for the previous cycle's frame is present |
| verdict_accept | output | 1 | 1 = frame kept, 0 = frame dropped |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The assertions check the following on every cycle:
- each drop rule sets its error bit and yields a drop verdict;
- the two acceptance modes keep the too-long and CRC bits clear;
- a write-1 clear with no competing event empties the bit;
- the interrupt only rises after a frame or a register write.

Only the bench scenarios can show some behaviours:
- the exact register readback layout;
- the length boundary at 1518 versus 1519;
- combined drop causes under each mode combination;
- a set racing a clear on the same bit;
- the reset values.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;

    localparam int unsigned ADDR_STATUS = 0;
    localparam int unsigned ADDR_ENABLE = 1;
    localparam int unsigned ADDR_MODE   = 2;

    localparam int unsigned SRC_COUNT   = 4;
    localparam int unsigned SRC_LSB     = 1;
    localparam int unsigned MODE_W      = 2;

    localparam int unsigned MODE_KEEP_LONG = 0;
    localparam int unsigned MODE_KEEP_CRC  = 1;

    // packed order matches register bits 4..1
    typedef struct packed {
        logic good;
        logic too_long;
        logic ovf;
        logic crc_err;
    } rx_src_t;

    typedef struct packed {
        logic keep_crc;
        logic keep_long;
    } rx_mode_t;

    typedef struct packed {
        logic valid;
        logic accept;
    } rx_verdict_t;

    function automatic rx_src_t src_from_bits(input logic [SRC_COUNT-1:0] b);
        rx_src_t s;
        s = rx_src_t'(b);
        return s;
    endfunction

    function automatic logic src_any(input rx_src_t a, input rx_src_t b);
        return |(a & b);
    endfunction

endpackage

// File: rtl/rx_frame_classifier.sv
module rx_frame_classifier
    import rx_stat_pkg::*;
#(
    parameter int unsigned LEN_W   = 16,
    parameter int unsigned MAX_LEN = 1518
) (
    input  logic             eof_valid,
    input  logic [LEN_W-1:0] frame_len,
    input  logic             crc_bad,
    input  logic             fifo_ovf,
    input  rx_mode_t         mode,
    output rx_src_t          set_evt,
    output logic             accept
);
    localparam logic [LEN_W-1:0] LEN_LIMIT = LEN_W'(MAX_LEN);

    logic over_len;
    logic drop_long;
    logic drop_crc;
    logic drop_ovf;

    always_comb begin
        over_len  = frame_len > LEN_LIMIT;
        drop_long = over_len && !mode.keep_long;
        drop_crc  = crc_bad && !mode.keep_crc;
        drop_ovf  = fifo_ovf;
        accept    = !(drop_long || drop_crc || drop_ovf);

        set_evt          = '0;
        set_evt.good     = eof_valid && accept;
        set_evt.too_long = eof_valid && drop_long;
        set_evt.ovf      = eof_valid && drop_ovf;
        set_evt.crc_err  = eof_valid && drop_crc;
    end
endmodule

// File: rtl/rx_status_bank.sv
module rx_status_bank
    import rx_stat_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  rx_src_t set_evt,
    input  rx_src_t clr_req,
    output rx_src_t status
);
    logic [SRC_COUNT-1:0] set_b;
    logic [SRC_COUNT-1:0] clr_b;
    logic [SRC_COUNT-1:0] stat_b;

    assign set_b  = set_evt;
    assign clr_b  = clr_req;
    assign status = src_from_bits(stat_b);

    for (genvar i = 0; i < SRC_COUNT; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stat_b[i] <= 1'b0;
            end else if (set_b[i]) begin
                stat_b[i] <= 1'b1;   // set beats clear
            end else if (clr_b[i]) begin
                stat_b[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rx_ctrl_regs.sv
module rx_ctrl_regs
    import rx_stat_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned DATA_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  rx_src_t           status,
    output rx_src_t           enable,
    output rx_mode_t          mode,
    output rx_src_t           clr_req,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int unsigned SRC_MSB = SRC_LSB + SRC_COUNT - 1;

    logic    wr_stat;
    logic    wr_en;
    logic    wr_mode;
    rx_src_t wsrc;

    always_comb begin
        wr_stat = reg_wr && (reg_addr == ADDR_W'(ADDR_STATUS));
        wr_en   = reg_wr && (reg_addr == ADDR_W'(ADDR_ENABLE));
        wr_mode = reg_wr && (reg_addr == ADDR_W'(ADDR_MODE));
        wsrc    = src_from_bits(reg_wdata[SRC_MSB:SRC_LSB]);
        clr_req = wr_stat ? wsrc : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '0;
            mode   <= '0;
        end else begin
            if (wr_en)   enable <= wsrc;
            if (wr_mode) mode   <= rx_mode_t'(reg_wdata[MODE_W-1:0]);
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_W'(ADDR_STATUS): reg_rdata[SRC_MSB:SRC_LSB] = status;
            ADDR_W'(ADDR_ENABLE): reg_rdata[SRC_MSB:SRC_LSB] = enable;
            ADDR_W'(ADDR_MODE):   reg_rdata[MODE_W-1:0]      = mode;
            default:              reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rx_frame_status.sv
module rx_frame_status
    import rx_stat_pkg::*;
#(
    parameter int unsigned LEN_W   = 16,
    parameter int unsigned MAX_LEN = 1518,
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned DATA_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              eof_valid,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              crc_bad,
    input  logic              fifo_ovf,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              verdict_valid,
    output logic              verdict_accept,
    output logic              rx_irq
);
    rx_src_t     set_evt;
    rx_src_t     clr_req;
    rx_src_t     status;
    rx_src_t     enable;
    rx_mode_t    mode;
    logic        accept;
    rx_verdict_t verdict_q;

    rx_frame_classifier #(
        .LEN_W   (LEN_W),
        .MAX_LEN (MAX_LEN)
    ) u_classify (
        .eof_valid (eof_valid),
        .frame_len (frame_len),
        .crc_bad   (crc_bad),
        .fifo_ovf  (fifo_ovf),
        .mode      (mode),
        .set_evt   (set_evt),
        .accept    (accept)
    );

    rx_status_bank u_status (
        .clk     (clk),
        .rst     (rst),
        .set_evt (set_evt),
        .clr_req (clr_req),
        .status  (status)
    );

    rx_ctrl_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .status    (status),
        .enable    (enable),
        .mode      (mode),
        .clr_req   (clr_req),
        .reg_rdata (reg_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            verdict_q <= '0;
        end else begin
            verdict_q.valid  <= eof_valid;
            verdict_q.accept <= eof_valid && accept;
        end
    end

    assign verdict_valid  = verdict_q.valid;
    assign verdict_accept = verdict_q.accept;
    assign rx_irq         = src_any(status, enable);
endmodule

// File: rtl/rx_status_checker.sv
module rx_status_checker #(
    parameter int unsigned LEN_W   = 16,
    parameter int unsigned MAX_LEN = 1518,
    parameter int unsigned ADDR_W  = 2,
    parameter int unsigned DATA_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              eof_valid,
    input logic [LEN_W-1:0]  frame_len,
    input logic              crc_bad,
    input logic              fifo_ovf,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [3:0]        stat,
    input logic [1:0]        mode,
    input logic              verdict_valid,
    input logic              verdict_accept,
    input logic              rx_irq
);
    logic over;
    logic stat_wr;
    assign over    = frame_len > LEN_W'(MAX_LEN);
    assign stat_wr = reg_wr && (reg_addr == '0);

    p_long_drop_r1: assert property (@(posedge clk) disable iff (rst)
        (eof_valid && over && !mode[0]) |=> (stat[2] && verdict_valid && !verdict_accept));

    p_long_keep_r2: assert property (@(posedge clk) disable iff (rst)
        (eof_valid && over && mode[0] && !stat[2]) |=> !stat[2]);

    p_crc_drop_r3: assert property (@(posedge clk) disable iff (rst)
        (eof_valid && crc_bad && !mode[1]) |=> (stat[0] && !verdict_accept));

    p_crc_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (eof_valid && crc_bad && mode[1] && !stat[0]) |=> !stat[0]);

    p_ovf_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (eof_valid && fifo_ovf) |=> (stat[1] && verdict_valid && !verdict_accept));

    p_good_r6: assert property (@(posedge clk) disable iff (rst)
        (eof_valid && !fifo_ovf && !over && !crc_bad) |=> (stat[3] && verdict_accept));

    p_w1c_good_r7: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && reg_wdata[4] && !eof_valid) |=> !stat[3]);

    p_w1c_crc_r7: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && reg_wdata[1] && !eof_valid) |=> !stat[0]);

    p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_irq) |-> ($past(eof_valid) || $past(reg_wr)));

    p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
        (eof_valid && fifo_ovf && stat_wr && reg_wdata[2]) |=> stat[1]);
endmodule

bind rx_frame_status rx_status_checker #(
    .LEN_W   (LEN_W),
    .MAX_LEN (MAX_LEN),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W)
) u_rx_status_checker (
    .clk            (clk),
    .rst            (rst),
    .eof_valid      (eof_valid),
    .frame_len      (frame_len),
    .crc_bad        (crc_bad),
    .fifo_ovf       (fifo_ovf),
    .reg_wr         (reg_wr),
    .reg_addr       (reg_addr),
    .reg_wdata      (reg_wdata),
    .stat           (status),
    .mode           (mode),
    .verdict_valid  (verdict_valid),
    .verdict_accept (verdict_accept),
    .rx_irq         (rx_irq)
);

// File: tb/test_rx_frame_status.sv
module test_rx_frame_status;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        eof_valid = 1'b0;
    logic [15:0] frame_len = '0;
    logic        crc_bad = 1'b0;
    logic        fifo_ovf = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [4:0]  reg_wdata = '0;
    logic [4:0]  reg_rdata;
    logic        verdict_valid;
    logic        verdict_accept;
    logic        rx_irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_frame_status i_rx_frame_status (
        .clk            (clk),
        .rst            (rst),
        .eof_valid      (eof_valid),
        .frame_len      (frame_len),
        .crc_bad        (crc_bad),
        .fifo_ovf       (fifo_ovf),
        .reg_wr         (reg_wr),
        .reg_addr       (reg_addr),
        .reg_wdata      (reg_wdata),
        .reg_rdata      (reg_rdata),
        .verdict_valid  (verdict_valid),
        .verdict_accept (verdict_accept),
        .rx_irq         (rx_irq)
    );

    // {len, crc, ovf, mode[1:0], expected status[4:1], expected accept}
    localparam logic [24:0] VEC [NVEC] = '{
        {16'd64,   1'b0, 1'b0, 2'b00, 4'b1000, 1'b1},
        {16'd1518, 1'b0, 1'b0, 2'b00, 4'b1000, 1'b1},
        {16'd1519, 1'b0, 1'b0, 2'b00, 4'b0100, 1'b0},
        {16'd1519, 1'b0, 1'b0, 2'b01, 4'b1000, 1'b1},
        {16'd100,  1'b1, 1'b0, 2'b00, 4'b0001, 1'b0},
        {16'd100,  1'b1, 1'b0, 2'b10, 4'b1000, 1'b1},
        {16'd200,  1'b0, 1'b1, 2'b00, 4'b0010, 1'b0},
        {16'd2000, 1'b1, 1'b1, 2'b00, 4'b0111, 1'b0},
        {16'd2000, 1'b1, 1'b1, 2'b11, 4'b0010, 1'b0},
        {16'd2000, 1'b1, 1'b0, 2'b11, 4'b1000, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [4:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [4:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic frame(input logic [15:0] l, input logic c, input logic o);
        eof_valid = 1'b1; frame_len = l; crc_bad = c; fifo_ovf = o;
        @(negedge clk);
        eof_valid = 1'b0; crc_bad = 1'b0; fifo_ovf = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [4:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12 reset state
        rd(2'd0, r); check("R12 status", r, 0);
        rd(2'd1, r); check("R12 enable", r, 0);
        rd(2'd2, r); check("R12 mode", r, 0);
        check("R12 irq", rx_irq, 0);
        check("R12 verdict", verdict_valid, 0);

        // table: R1 R2 R3 R4 R5 R6 R11
        for (int i = 0; i < NVEC; i++) begin
            wr(2'd0, 5'h1E);
            wr(2'd2, {3'b0, VEC[i][6:5]});
            frame(VEC[i][24:9], VEC[i][8], VEC[i][7]);
            check($sformatf("R6 verdict_valid vec%0d", i), verdict_valid, 1);
            check($sformatf("R1-R6 accept vec%0d", i), verdict_accept, VEC[i][0]);
            rd(2'd0, r);
            check($sformatf("R11 status vec%0d", i), r, {VEC[i][4:1], 1'b0});
        end
        @(negedge clk);
        check("R6 verdict one cycle", verdict_valid, 0);

        // R9 readback layout
        wr(2'd1, 5'h1F);
        rd(2'd1, r); check("R9 enable layout", r, 5'h1E);
        wr(2'd2, 5'h1F);
        rd(2'd2, r); check("R9 mode layout", r, 5'h03);
        rd(2'd3, r); check("R9 addr3", r, 0);
        wr(2'd2, 5'h00);
        wr(2'd1, 5'h00);

        // R7 write-0 no effect, write-1 clears selected bits
        wr(2'd0, 5'h1E);
        frame(16'd3000, 1'b1, 1'b1);
        rd(2'd0, r); check("R7 setup", r, 5'h0E);
        wr(2'd0, 5'h00);
        rd(2'd0, r); check("R7 write0 no effect", r, 5'h0E);
        wr(2'd0, 5'h04);
        rd(2'd0, r); check("R7 clear bit2 only", r, 5'h0A);

        // R8 interrupt
        wr(2'd0, 5'h1E);
        frame(16'd100, 1'b1, 1'b0);
        check("R8 irq disabled", rx_irq, 0);
        wr(2'd1, 5'h10);
        check("R8 other enable", rx_irq, 0);
        wr(2'd1, 5'h02);
        check("R8 matching enable", rx_irq, 1);
        wr(2'd0, 5'h02);
        check("R8 irq after clear", rx_irq, 0);
        wr(2'd1, 5'h00);

        // R10 set wins over simultaneous clear
        wr(2'd0, 5'h1E);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 5'h10;
        frame(16'd64, 1'b0, 1'b0);
        reg_wr = 1'b0;
        rd(2'd0, r); check("R10 good set wins", r, 5'h10);
        reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 5'h1E;
        frame(16'd64, 1'b1, 1'b0);
        reg_wr = 1'b0;
        rd(2'd0, r); check("R10 crc set wins, good cleared", r, 5'h02);

        // R6 dropped frame leaves good bit unchanged
        wr(2'd0, 5'h1E);
        frame(16'd64, 1'b0, 1'b0);
        frame(16'd64, 1'b0, 1'b1);
        rd(2'd0, r); check("R6 good kept after drop", r, 5'h14);

        // R12 reset mid-run
        wr(2'd1, 5'h1E);
        wr(2'd2, 5'h03);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        rd(2'd0, r); check("R12 status after reset", r, 0);
        rd(2'd1, r); check("R12 enable after reset", r, 0);
        rd(2'd2, r); check("R12 mode after reset", r, 0);
        check("R12 irq after reset", rx_irq, 0);

        finish_run();
    end
endmodule